// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block is a hardware sequencer that finds an Ethernet PHY attached to a management bus without software help. After a start pulse it waits for a programmable settle time. It then probes each management address in turn and reads the PHY identifier registers. When no address answers, it sweeps again, up to a fixed number of passes, so that a PHY that is still coming out of reset can wake up. The block does not drive the serial management waveform itself. It hands each register read to a separate management engine and takes back the 16-bit result.

A sweep reads the lower identifier register (register 3) first. A reply of all ones means no device sits at that address. Any other reply makes the block read the upper identifier register (register 2) at the same address. The two halves become a 32-bit identifier, and the scan ends. When the last pass ends with nothing found, the block reports failure.

The request port uses valid/ready. `req_valid` rises with a stable address and register number and holds them until the engine asserts `req_ready`. A transfer occurs on a clock edge where both are high. The response side is also valid/ready. The block raises `rsp_ready` only while it waits for a reply. The engine must hold `rsp_valid` and `rsp_data` until a rising edge where `rsp_ready` is high. A request and a reply wait are never outstanding together.

Top module: `phy_scan`

## Requirements
- R1: After reset, `done`, `found`, `req_valid` and `rsp_ready` are low, and `phy_addr` and `phy_id` are zero.
- R2: A start pulse sampled in idle on clock edge t makes the first request of the first pass present after edge t+W+1, where W is the value on `pass_wait`.
- R3: Within a pass, addresses are probed in ascending order from 0 to 31. The first read at each address uses register number 3.
- R4: A register-3 reply of 0xFFFF marks the address as empty, and the next probe moves to the next address. Any other reply is followed by a register-2 read at the same address.
- R5: After the register-2 reply, `found` is high and `phy_addr` holds the first responding address. `phy_id` holds the register-2 reply in bits 31:16 and the register-3 reply in bits 15:0. A register-2 reply of 0xFFFF is still accepted as data.
- R6: At most MAX_PASSES (11) passes are made. If the last pass finds nothing, `done` pulses with `found` low, `phy_addr` all ones and `phy_id` zero.
- R7: `done` is a one-cycle pulse, and exactly one pulse comes per scan. The result outputs keep their values after the pulse until the next result.
- R8: While `req_valid` is high and `req_ready` is low, the request and its address and register fields stay unchanged. A reply is accepted only while `rsp_ready` is high. `req_valid` and `rsp_ready` are never high together.
- R9: A start pulse while a scan is running has no effect on the probe sequence, the result or the number of `done` pulses.
- R10: When address 31 of a pass comes back empty and passes remain, the next request (address 0, register 3) is present after edge t+W+1, where t is the edge that accepted that reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (honoured only when idle) |
| pass_wait | input | WAIT_W | Settle delay before each pass, in clock cycles |
| done | output | 1 | One-cycle pulse when the scan ends |
| found | output | 1 | A PHY was located |
| phy_addr | output | ADDR_W | Responding address, all ones when none |
| phy_id | output | 2*DATA_W | Combined identifier, upper half from register 2 |
| req_valid | output | 1 | Register read request pending |
| req_ready | input | 1 | Management engine accepts the request |
| req_phy | output | ADDR_W | Address for the read |
| req_reg | output | REG_W | Register number for the read |
| rsp_valid | input | 1 | Read result available |
| rsp_ready | output | 1 | Block waits for a result |
| rsp_data | input | DATA_W | Read result |

## Verification
Directed scans put the PHY at address 0 and at address 31 to cover both ends of the sweep. One PHY wakes only on the final pass, which separates a correct pass limit from one that is off by one. Another never wakes, which exercises the failure report with its all-ones address. Random scans vary the PHY address, the wake-up pass, the settle delay, the grant stall and the reply latency. Every request is compared with the expected address and register order. The first request of each pass is timed against the settle delay. A register-2 reply of all ones shows that only the register-3 reply decides presence. A start pulse injected mid-scan shows that the running sweep is left untouched.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ASK_LO,
    ST_GET_LO,
    ST_ASK_HI,
    ST_GET_HI
  } scan_state_t;

  localparam int unsigned ID_HI_REG = 2;
  localparam int unsigned ID_LO_REG = 3;
endpackage

// File: rtl/phy_scan_delay.sv
module phy_scan_delay #(
  parameter int WAIT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] len,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_DELAY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(len)))  // R2
    else $error("delay load mismatch");
endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
  import phy_scan_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int MAX_PASSES = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                expired,
  output logic                load,
  output logic                done,
  output logic                found,
  output logic [ADDR_W-1:0]   phy_addr,
  output logic [2*DATA_W-1:0] phy_id,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_phy,
  output logic [REG_W-1:0]    req_reg,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [DATA_W-1:0]   rsp_data
);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR  = '1;
  localparam logic [DATA_W-1:0] ABSENT     = '1;
  localparam logic [PASS_W-1:0] LAST_PASS  = PASS_W'(MAX_PASSES - 1);
  localparam logic [REG_W-1:0]  REG_HI     = REG_W'(ID_HI_REG);
  localparam logic [REG_W-1:0]  REG_LO     = REG_W'(ID_LO_REG);

  scan_state_t         st_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [PASS_W-1:0]   pass_q;
  logic [DATA_W-1:0]   lo_q;
  logic                done_q, found_q;
  logic [ADDR_W-1:0]   paddr_q;
  logic [2*DATA_W-1:0] id_q;

  logic lo_empty, sweep_end;
  assign lo_empty  = (st_q == ST_GET_LO) && rsp_valid && (rsp_data == ABSENT);
  assign sweep_end = lo_empty && (addr_q == LAST_ADDR);

  assign load = ((st_q == ST_IDLE) && start) || (sweep_end && (pass_q != LAST_PASS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      pass_q  <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      paddr_q <= '0;
      id_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_SETTLE;
          addr_q <= '0;
          pass_q <= '0;
        end
        ST_SETTLE: if (expired) st_q <= ST_ASK_LO;
        ST_ASK_LO: if (req_ready) st_q <= ST_GET_LO;
        ST_GET_LO: if (rsp_valid) begin
          if (rsp_data != ABSENT) begin
            lo_q <= rsp_data;
            st_q <= ST_ASK_HI;
          end else if (addr_q != LAST_ADDR) begin
            addr_q <= addr_q + 1'b1;
            st_q   <= ST_ASK_LO;
          end else if (pass_q != LAST_PASS) begin
            addr_q <= '0;
            pass_q <= pass_q + 1'b1;
            st_q   <= ST_SETTLE;
          end else begin
            done_q  <= 1'b1;
            found_q <= 1'b0;
            paddr_q <= '1;
            id_q    <= '0;
            st_q    <= ST_IDLE;
          end
        end
        ST_ASK_HI: if (req_ready) st_q <= ST_GET_HI;
        ST_GET_HI: if (rsp_valid) begin
          done_q  <= 1'b1;
          found_q <= 1'b1;
          paddr_q <= addr_q;
          id_q    <= {rsp_data, lo_q};
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == ST_ASK_LO) || (st_q == ST_ASK_HI);
  assign req_reg   = (st_q == ST_ASK_HI) ? REG_HI : REG_LO;
  assign req_phy   = addr_q;
  assign rsp_ready = (st_q == ST_GET_LO) || (st_q == ST_GET_HI);
  assign done      = done_q;
  assign found     = found_q;
  assign phy_addr  = paddr_q;
  assign phy_id    = id_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_phy) && $stable(req_reg)))  // R8
    else $error("request dropped or changed while stalled");
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready))  // R8
    else $error("request and reply wait overlap");
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)  // R7
    else $error("done longer than one cycle");
  AST_MISS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> ((phy_addr == LAST_ADDR) && (phy_id == '0)))  // R6
    else $error("failure report malformed");
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q <= LAST_PASS)  // R6
    else $error("pass counter beyond limit");
  AST_HI_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_GET_LO) && rsp_valid && (rsp_data != ABSENT)) |=> (req_valid && req_reg == REG_HI && $stable(req_phy)))  // R4
    else $error("upper id read not at same address");
endmodule

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int ADDR_W     = 5,
  parameter int REG_W      = 5,
  parameter int DATA_W     = 16,
  parameter int MAX_PASSES = 11,
  parameter int WAIT_W     = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WAIT_W-1:0]   pass_wait,
  output logic                done,
  output logic                found,
  output logic [ADDR_W-1:0]   phy_addr,
  output logic [2*DATA_W-1:0] phy_id,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [ADDR_W-1:0]   req_phy,
  output logic [REG_W-1:0]    req_reg,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [DATA_W-1:0]   rsp_data
);
  logic tmr_load, tmr_expired;

  phy_scan_delay #(.WAIT_W(WAIT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(pass_wait), .expired(tmr_expired)
  );

  phy_scan_seq #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W), .MAX_PASSES(MAX_PASSES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .expired(tmr_expired), .load(tmr_load),
    .done(done), .found(found), .phy_addr(phy_addr), .phy_id(phy_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !req_valid))  // R1
    else $error("activity right after reset");
endmodule

// File: tb/test_phy_scan.sv
module test_phy_scan;
  localparam int MAXP = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pass_wait = '0;
  logic        done, found, req_valid, rsp_ready;
  logic [4:0]  phy_addr, req_phy, req_reg;
  logic [31:0] phy_id;
  logic        req_ready = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  phy_scan i_phy_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .pass_wait(pass_wait),
    .done(done), .found(found), .phy_addr(phy_addr), .phy_id(phy_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_found(input int k);
    return k < MAXP;
  endfunction

  function automatic int exp_passes(input int k);
    return (k < MAXP) ? k + 1 : MAXP;
  endfunction

  task automatic run_scan(input int p, input int k, input int w, input logic [31:0] id, input bit poke);
    int cyc = 0, pend = 0, dcnt = 0, fin = 0, ref_cyc = 0, npass = 0;
    bit armed = 1'b1, fin_seen = 1'b0, end_pass = 1'b0;
    int e_addr = 0, e_reg = 3, e_pass = 0;
    logic [15:0] pdata = '0;
    bit g_f = 1'b0;
    logic [4:0] g_a = '0;
    logic [31:0] g_id = '0;
    pass_wait = 20'(w);
    @(negedge clk);
    start = 1'b1;
    while (cyc < 30000) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == w + 6);
      if (done) begin
        dcnt++;
        g_f = found; g_a = phy_addr; g_id = phy_id;
        if (!fin_seen) begin fin_seen = 1'b1; fin = cyc; end
      end
      rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          check(rsp_ready === 1'b1, "R8 reply offered outside wait", {31'd0, rsp_ready}, 32'd1);
          rsp_valid = 1'b1;
          rsp_data  = pdata;
          if (end_pass) begin ref_cyc = cyc; armed = 1'b1; end_pass = 1'b0; end
        end
      end
      req_ready = 1'b0;
      if (req_valid) begin
        if (armed) begin
          check(cyc == ref_cyc + w + 2, "R2/R10 settle delay before pass", 32'(cyc - ref_cyc), 32'(w + 2));
          armed = 1'b0;
        end
        if ($urandom % 3 != 0) begin
          bit here;
          req_ready = 1'b1;
          check(int'(req_phy) == e_addr && int'(req_reg) == e_reg, "R3/R4 probe order",
                {19'd0, req_phy, 3'd0, req_reg}, {19'(e_addr), 3'd0, 5'(e_reg)});
          if (req_reg == 5'd3 && req_phy == 5'd0) npass++;
          here = (e_pass >= k) && (int'(req_phy) == p);
          if (req_reg == 5'd3) begin
            pdata = here ? id[15:0] : 16'hFFFF;
            if (here) e_reg = 2;
            else if (e_addr == 31) begin
              e_pass++; e_addr = 0;
              if (e_pass < MAXP) end_pass = 1'b1;
            end else e_addr++;
          end else begin
            pdata = id[31:16];
            e_reg = 99;
          end
          pend = 1 + int'($urandom % 3);
        end
      end
      if (fin_seen && cyc >= fin + 6) break;
    end
    start = 1'b0;
    check(fin_seen, "R7 scan finished", {31'd0, fin_seen}, 32'd1);
    check(dcnt == 1, poke ? "R9 one done despite busy start" : "R7 single done pulse", 32'(dcnt), 32'd1);
    check(npass == exp_passes(k), poke ? "R9 passes unchanged" : "R6/R10 pass count", 32'(npass), 32'(exp_passes(k)));
    if (exp_found(k)) begin
      check(g_f == 1'b1, "R5 found flag", {31'd0, g_f}, 32'd1);
      check(int'(g_a) == p, "R5 address", {27'd0, g_a}, 32'(p));
      check(g_id == id, "R5 identifier", g_id, id);
    end else begin
      check(g_f == 1'b0, "R6 found low", {31'd0, g_f}, 32'd0);
      check(g_a == 5'h1F, "R6 address all ones", {27'd0, g_a}, 32'h1F);
      check(g_id == 32'd0, "R6 id zero", g_id, 32'd0);
    end
    check(phy_addr == g_a && phy_id == g_id && found == g_f, "R7 result held",
          {27'd0, phy_addr}, {27'd0, g_a});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!done && !found && !req_valid && !rsp_ready && phy_addr == 5'd0 && phy_id == 32'd0,
          "R1 reset state", {27'd0, done, found, req_valid, rsp_ready, 1'b0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_scan(0,  0,  3, 32'h0022_1619, 1'b0);
    run_scan(31, 0,  0, 32'h1234_5678, 1'b0);
    run_scan(5,  10, 2, 32'hABCD_0000, 1'b0);
    run_scan(7,  11, 1, 32'h0, 1'b0);
    run_scan(3,  2,  0, 32'hFFFF_0042, 1'b0);
    run_scan(9,  1,  4, 32'h0141_0CC2, 1'b1);
    for (int i = 0; i < 8; i++) begin
      int p = int'($urandom % 32);
      int k = int'($urandom % 13);
      int w = int'($urandom % 16);
      logic [31:0] id = {16'($urandom), 16'($urandom) & 16'hFFFE};
      run_scan(p, k, w, id, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule